// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This controller sits between a clocked host and an external asynchronous static RAM that is 16 bits wide, with separate strobes for its lower and upper byte lanes. The host presents one request at a time: a write flag, a word address, write data and a two-bit lane mask. The controller then runs one memory access and reports its end with a single-cycle done pulse. For a read, the captured word comes out at the same time as that pulse.

Every timing window on the memory side is a whole number of clock cycles. Each count comes from a nanosecond figure divided by the clock period and rounded up. The address is put on the memory pins only while every strobe is inactive. Write enable, chip enable and the selected lane strobes all go active together. The controller drives the data bus only inside the write pulse, and it starts one or more cycles after write enable falls. After a read, all strobes go high and the bus is left floating for a turnaround window before any new access can start.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both lane strobes are high (inactive). The bus drive enable and done are low, and reqReady is high.
- R2: A request is taken only when reqReady is high. reqValid is ignored while an access is in progress, so neither the memory address nor the memory contents change because of it.
- R3: memAddr changes only while write enable, chip enable and both lane strobes are all high.
- R4: A read holds chip enable and output enable low, with write enable high, for RD_CYC = max(ceil(tRC/Tclk), ceil(tAA/Tclk)) cycles (6 at defaults). Mask bit 0 selects the lower lane (data bits 7:0) and mask bit 1 selects the upper lane (bits 15:8). The bus is sampled in the last of those cycles, and an unselected lane reads back as zero.
- R5: done is high for exactly one cycle, the cycle after the last active strobe cycle. Counting the edge that accepts the request as edge 1, done is seen after edge RD_CYC+2 for a read and after edge WP_CYC+2 for a write.
- R6: A write holds chip enable, write enable and the masked lane strobes low together for WP_CYC = max(ceil(tWP/Tclk), DRV_WAIT+ceil(tDW/Tclk)) cycles (5 at defaults). Output enable stays high during the pulse unless the output-enable-held mode is chosen.
- R7: The data bus is driven only while write enable is low. Driving starts DRV_WAIT cycles after the falling edge (1 by default; ceil(tWHZ/Tclk) in the output-enable-held mode) and stops at the edge where write enable rises. The bus is never driven in a cycle in which the memory drives it.
- R8: A write with mask 00 changes no memory lane.
- R9: After a read, all strobes stay high and the bus stays released for HZ_CYC = ceil(tHZ/Tclk) cycles (2 at defaults), counted from the done cycle, before reqReady returns. After a write, this recovery window lasts REC_CYC = max(1, ceil(tWC/Tclk)-1-WP_CYC) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken while reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| reqReady | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle end-of-access pulse |
| rdData | output | DATA_W | Read word, valid with done after a read |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memDqOut | output | DATA_W | Data toward the memory |
| memDqOe | output | 1 | Tristate enable for memDqOut |
| memDqIn | input | DATA_W | Data from the memory bus |

## Verification
The bench counts rising edges from the accepting edge to the edge that makes done visible, and expects RD_CYC+2 for a read and WP_CYC+2 for a write. It then counts further edges until reqReady returns, and expects HZ_CYC after a read and REC_CYC after a write. All sampling happens on the falling clock edge. Read data is compared in the same half cycle in which done is first seen. The widths of the write-enable and output-enable pulses and the first cycle of bus drive are measured by a monitor on every cycle, so each window is checked against the counts listed in R4, R6 and R7.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RD,
    ST_RDHZ,
    ST_WRP,
    ST_WRREC
  } ctlState_t;

  // Strobes from control to datapath, all active high
  typedef struct packed {
    logic load;
    logic ceAct;
    logic oeAct;
    logic weAct;
    logic selAct;
    logic drive;
    logic capture;
  } ctlStrobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC       = 6,
  parameter int WP_CYC       = 5,
  parameter int DRV_WAIT     = 1,
  parameter int REC_CYC      = 1,
  parameter int HZ_CYC       = 2,
  parameter int OE_LOW_WRITE = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       doneQ,
  output ctlStrobe_t strobe
);

  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LAST  = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_AT   = CNT_W'(DRV_WAIT);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;

  // Elaboration-time guard: every window must be at least one cycle
  initial begin
    assert (RD_CYC > 0 && WP_CYC > 0 && REC_CYC > 0 && HZ_CYC > 0 && DRV_WAIT > 0
            && DRV_WAIT < WP_CYC)
      else $error("sram_ctl_fsm: a timing count is zero or the drive wait is too long");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_ADDR;
            isWrite <= reqWrite;
            cnt     <= '0;
          end
        end
        ST_ADDR: begin
          state <= isWrite ? ST_WRP : ST_RD;
          cnt   <= '0;
        end
        ST_RD: begin
          if (cnt == RD_LAST) begin
            state <= ST_RDHZ;
            cnt   <= '0;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RDHZ: begin
          if (cnt == HZ_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRP: begin
          if (cnt == WP_LAST) begin
            state <= ST_WRREC;
            cnt   <= '0;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRREC: begin
          if (cnt == REC_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe   = '0;
    reqReady = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: strobe.load = reqValid;
      ST_RD: begin
        strobe.ceAct   = 1'b1;
        strobe.oeAct   = 1'b1;
        strobe.selAct  = 1'b1;
        strobe.capture = (cnt == RD_LAST);
      end
      ST_WRP: begin
        strobe.ceAct  = 1'b1;
        strobe.weAct  = 1'b1;
        strobe.selAct = 1'b1;
        strobe.oeAct  = (OE_LOW_WRITE != 0);
        strobe.drive  = (cnt >= DRV_AT);
      end
      default: ;
    endcase
  end

  // R5: done never lasts two cycles
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R2: no request is taken in the cycle right after done, which lies inside an access
  a_r2_busy_after_done: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !reqReady);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  // One capture register per lane; an unselected lane reads back as zero
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdQ[lane*LANE_W +: LANE_W] <= '0;
      end else if (strobe.capture) begin
        rdQ[lane*LANE_W +: LANE_W] <= maskQ[lane] ? memDqIn[lane*LANE_W +: LANE_W]
                                                  : '0;
      end
    end
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~strobe.ceAct;
  assign memOeN   = ~strobe.oeAct;
  assign memWeN   = ~strobe.weAct;
  assign memLbN   = ~(strobe.selAct & maskQ[0]);
  assign memUbN   = ~(strobe.selAct & maskQ[1]);
  assign memDqOut = wdataQ;
  assign memDqOe  = strobe.drive;
  assign rdData   = rdQ;

  // R3: the address moves only while every strobe is inactive
  a_r3_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> (memWeN && memCeN && memLbN && memUbN));

  // R7: bus driven only inside the write pulse
  a_r7_drive_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memWeN);

  // R7: no drive in the cycle write enable falls
  a_r7_no_drive_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> !memDqOe);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 10,
  parameter int T_RC_NS      = 55,
  parameter int T_AA_NS      = 55,
  parameter int T_WC_NS      = 55,
  parameter int T_WP_NS      = 45,
  parameter int T_DW_NS      = 25,
  parameter int T_WHZ_NS     = 20,
  parameter int T_HZ_NS      = 20,
  parameter int OE_LOW_WRITE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC   = imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS));
  localparam int DRV_WAIT = (OE_LOW_WRITE != 0) ? imax(1, cdiv(T_WHZ_NS, CLK_NS)) : 1;
  localparam int WP_CYC   = imax(cdiv(T_WP_NS, CLK_NS), DRV_WAIT + cdiv(T_DW_NS, CLK_NS));
  localparam int REC_CYC  = imax(1, cdiv(T_WC_NS, CLK_NS) - 1 - WP_CYC);
  localparam int HZ_CYC   = imax(1, cdiv(T_HZ_NS, CLK_NS));

  ctlStrobe_t strobe;

  sram_ctl_fsm #(
    .RD_CYC      (RD_CYC),
    .WP_CYC      (WP_CYC),
    .DRV_WAIT    (DRV_WAIT),
    .REC_CYC     (REC_CYC),
    .HZ_CYC      (HZ_CYC),
    .OE_LOW_WRITE(OE_LOW_WRITE)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .doneQ   (done),
    .strobe  (strobe)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memLbN  (memLbN),
    .memUbN  (memUbN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rdData  (rdData)
  );

  // R2: while busy the address held at the pins does not move
  a_r2_busy_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(memAddr));

  // R4: output enable and write enable are never active together in the default mode
  a_r4_oe_we_apart: assert property (@(posedge clk) disable iff (!rstN)
    (OE_LOW_WRITE == 0) |-> !(!memOeN && !memWeN));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int AW = 18;
  localparam int DW = 16;
  // Expected windows worked out from 10 ns clock and the ns figures
  localparam int RDC = 6;   // max(55,55)/10 rounded up
  localparam int WPC = 5;   // max(45/10 -> 5, 1 + 25/10 -> 4)
  localparam int HZC = 2;   // 20/10
  localparam int RCC = 1;   // max(1, 6-1-5)
  localparam int VW  = 41;  // {wr, addr6, data16, mask2, exp16}
  localparam int NV  = 13;

  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {1'b1, 6'd5, 16'hA1B2, 2'b11, 16'h0000},
    {1'b0, 6'd5, 16'h0000, 2'b11, 16'hA1B2},
    {1'b1, 6'd5, 16'hFFFF, 2'b01, 16'h0000},
    {1'b0, 6'd5, 16'h0000, 2'b11, 16'hA1FF},
    {1'b1, 6'd5, 16'h3C00, 2'b10, 16'h0000},
    {1'b0, 6'd5, 16'h0000, 2'b11, 16'h3CFF},
    {1'b0, 6'd5, 16'h0000, 2'b01, 16'h00FF},
    {1'b0, 6'd5, 16'h0000, 2'b10, 16'h3C00},
    {1'b1, 6'd9, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 6'd9, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 6'd9, 16'h5678, 2'b00, 16'h0000},
    {1'b0, 6'd9, 16'h0000, 2'b11, 16'h1234},
    {1'b0, 6'd5, 16'h0000, 2'b11, 16'h3CFF}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0]    reqMask = '0;
  logic          reqReady, done;
  logic [DW-1:0] rdData, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;
  logic          memCeN, memOeN, memWeN, memLbN, memUbN, memDqOe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .done(done), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memLbN(memLbN), .memUbN(memUbN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  // Behavioural memory: 64 words, byte-lane writes, floating lanes read as A5
  logic [DW-1:0] model [0:63];
  logic          modelDrive;
  logic [5:0]    mIdx;
  assign mIdx       = memAddr[5:0];
  assign modelDrive = !memCeN && !memOeN && memWeN && (!memLbN || !memUbN);
  assign memDqIn    = modelDrive ? {(memUbN ? 8'hA5 : model[mIdx][15:8]),
                                    (memLbN ? 8'hA5 : model[mIdx][7:0])}
                                 : (memDqOe ? memDqOut : 16'hA5A5);

  initial for (int i = 0; i < 64; i++) model[i] = '0;

  always @(posedge clk) begin
    if (!memCeN && !memWeN && memDqOe) begin
      if (!memLbN) model[mIdx][7:0]  <= memDqOut[7:0];
      if (!memUbN) model[mIdx][15:8] <= memDqOut[15:8];
    end
  end

  // Cycle monitor
  logic [AW-1:0] prevAddr = '0;
  int weCnt = 0, oeCnt = 0, lastWe = 0, lastOe = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memAddr != prevAddr && (!memWeN || !memCeN || !memLbN || !memUbN)) begin
        bad++; $display("FAIL R3 addr moved with strobe low: act=%h exp=%h", memAddr, prevAddr);
      end
      if (modelDrive && memDqOe) begin
        bad++; $display("FAIL R7 bus contention: act=1 exp=0");
      end
      if (memDqOe && memWeN) begin
        bad++; $display("FAIL R7 drive outside pulse: act=1 exp=0");
      end
      if (!memWeN) begin
        weCnt++;
        if (memDqOe && weCnt < 2) begin
          bad++; $display("FAIL R7 drive too early: act=%0d exp>=2", weCnt);
        end
        if (memCeN || !memOeN) begin
          bad++; $display("FAIL R6 pulse strobes: act=ce%0b oe%0b exp=ce0 oe1", memCeN, memOeN);
        end
      end else if (weCnt != 0) begin
        lastWe = weCnt; weCnt = 0;
      end
      if (!memOeN) oeCnt++;
      else if (oeCnt != 0) begin lastOe = oeCnt; oeCnt = 0; end
    end
    prevAddr = memAddr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Runs one access; returns edges to done (accepting edge = 1) and edges from done to ready
  task automatic doOp(input bit wr, input logic [5:0] a, input logic [DW-1:0] d,
                      input logic [1:0] m, output int lat, output int rec);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = {12'd0, a}; reqWdata = d; reqMask = m;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    rec = 0;
    while (!reqReady) begin
      @(posedge clk); rec++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, rec;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(memCeN && memOeN && memWeN && memLbN && memUbN, "R1 strobes idle",
        {memCeN, memOeN, memWeN, memLbN, memUbN}, 5'h1F);
    chk(!memDqOe && !done && reqReady, "R1 drive/done/ready",
        {memDqOe, done, reqReady}, 3'b001);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      doOp(e[40], e[39:34], e[33:18], e[17:16], lat, rec);
      if (e[40]) begin
        chk(lat == WPC + 2, "R5 write done latency", lat, WPC + 2);
        chk(lastWe == WPC, "R6 write pulse width", lastWe, WPC);
        chk(rec == RCC, "R9 write recovery", rec, RCC);
      end else begin
        chk(rdData == e[15:0], "R4/R8 read data", rdData, e[15:0]);
        chk(lat == RDC + 2, "R5 read done latency", lat, RDC + 2);
        chk(lastOe == RDC, "R4 read strobe width", lastOe, RDC);
        chk(rec == HZC, "R9 read turnaround", rec, HZC);
      end
    end

    // R5: done is a single-cycle pulse
    @(negedge clk);
    chk(!done, "R5 done dropped", done, 0);

    // R2: request during a read is ignored
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 18'd5; reqMask = 2'b11;
    @(posedge clk);
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 18'd7; reqWdata = 16'hBEEF;
    for (int k = 0; k < 3; k++) begin
      chk(!reqReady, "R2 busy ready low", reqReady, 0);
      chk(memAddr == 18'd5, "R2 addr held while busy", memAddr, 5);
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    chk(rdData == 16'h3CFF, "R2 original read intact", rdData, 16'h3CFF);
    doOp(1'b0, 6'd7, 16'h0, 2'b11, lat, rec);
    chk(rdData == 16'h0000, "R2 ignored write left memory", rdData, 0);

    // R3/R7 monitor result counted as a check
    chk(bad == 0, "R3/R7 cycle monitor clean", bad, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule